// File: doc/BRIEF.md
# Audio Interrupt Status Unit

This block gathers the interrupt sources of a serial audio controller into a single interrupt line. It holds an enable word and a pending-status word and drives a registered `irq` output. It also drives two DMA request lines. Three kinds of source feed the status word:

- **Level conditions** from the FIFOs: receive data available and transmit FIFO empty. These pending bits clear themselves when the condition goes away.
- **Single-cycle error pulses**: receive overrun, transmit overrun, transmit underrun and parity error. These pending bits are sticky.
- **Edges of the receiver lock flag**: one bit for gaining lock and one for losing it.

Software uses a simple register port. `reg_sel` picks the word: 0 is the enable word and 1 is the status word. A write to the enable word replaces it. A write to the status word clears every bit written as 1 and leaves the others alone. Reads are combinational and show the selected word. The FIFOs and the receiver sit outside this block and only supply the event and level inputs.

Top module: `aud_irq_ctrl`

## Requirements
- R1: After a synchronous reset, the enable word and the status word read 0, and `irq`, `rx_dma_req` and `tx_dma_req` are 0.
- R2: The writable enable bits are 0 (RX available), 1 (RX overrun), 2 (RX DMA), 4 (TX empty), 5 (TX overrun), 6 (TX underrun), 7 (TX DMA), 16 (parity), 17 (unlock) and 18 (lock). All other bits read 0, so writing all ones reads back 0x000700F7.
- R3: Writing the status word (`reg_sel`=1) clears each pending bit written as 1 and leaves each bit written as 0 unchanged. Status bits with no source read 0.
- R4: A one-cycle pulse on `rx_ovr_ev`, `tx_ovr_ev`, `tx_udr_ev` or `par_err_ev` sets status bit 1, 5, 6 or 16 respectively. The bit stays set until a 1 is written to it.
- R5: If a sticky event and a clearing write to the same bit occur in the same cycle, the bit ends up set.
- R6: Status bit 0 (RX available) and bit 4 (TX empty) set when `rx_avail` or `tx_empty` goes from 0 to 1. Such a bit clears in the cycle after its condition is low. A clearing write removes it while the condition stays high, and it does not set again until the condition rises anew.
- R7: Status bit 18 sets when `lock_flag` goes from 0 to 1. Status bit 17 sets when it goes from 1 to 0. Both are sticky until written with 1. The flag is taken as 0 during reset.
- R8: `irq` is a register. It shows, one cycle later, whether any status bit is set whose enable bit at the same position is also set.
- R9: In the same cycle as its inputs, `rx_dma_req` equals enable bit 2 AND `rx_avail`, and `tx_dma_req` equals enable bit 7 AND `tx_room`.
- R10: Status bits set whatever their enable bits hold. A pending bit that is not enabled leaves `irq` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | Word select: 0 enable, 1 status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected word |
| rx_avail | input | 1 | RX FIFO holds data (level) |
| tx_empty | input | 1 | TX FIFO empty (level) |
| tx_room | input | 1 | TX FIFO below its request threshold (level) |
| rx_ovr_ev | input | 1 | RX overrun pulse |
| tx_ovr_ev | input | 1 | TX overrun pulse |
| tx_udr_ev | input | 1 | TX underrun pulse |
| par_err_ev | input | 1 | Receiver parity error pulse |
| lock_flag | input | 1 | Receiver lock indication (level) |
| irq | output | 1 | Registered interrupt request |
| rx_dma_req | output | 1 | RX DMA request |
| tx_dma_req | output | 1 | TX DMA request |

## Verification
The bench targets five corner cases:

- **Event and clear in the same cycle.** A design that let the clear win would lose an overrun.
- **A clearing write while RX data is still available.** A bit that re-armed on the level instead of the rise would reassert at once.
- **A lock flag held high for several cycles and then dropped.** A design that set on the level would not separate lock from unlock.
- **The one-cycle lag of `irq` behind the status word, both when a bit sets and when it clears.** A combinational or two-stage path would show up here.
- **All-ones writes to the enable word and pending bits that are not enabled.** Missing masking or missing gating would show up as stray bits or a spurious interrupt.

// File: rtl/aud_irq_pkg.sv
package aud_irq_pkg;

    localparam int REG_W = 32;

    // bit positions shared by the enable and status words
    localparam int B_RX_AVAIL = 0;
    localparam int B_RX_OVR   = 1;
    localparam int B_RX_DMA   = 2;
    localparam int B_TX_EMPTY = 4;
    localparam int B_TX_OVR   = 5;
    localparam int B_TX_UDR   = 6;
    localparam int B_TX_DMA   = 7;
    localparam int B_PARITY   = 16;
    localparam int B_UNLOCK   = 17;
    localparam int B_LOCK     = 18;

    // level-type inputs watched for edges
    localparam int N_EDGE = 3;
    localparam int E_RX   = 0;
    localparam int E_TX   = 1;
    localparam int E_LOCK = 2;

    typedef enum logic [1:0] {
        PK_NONE,
        PK_STICKY,
        PK_LEVEL
    } pend_kind_e;

    typedef enum logic {
        SEL_ENABLE = 1'b0,
        SEL_STATUS = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic rx_avail;
        logic tx_empty;
        logic tx_room;
        logic rx_ovr;
        logic tx_ovr;
        logic tx_udr;
        logic par_err;
        logic lock;
    } aud_evt_t;

    function automatic pend_kind_e pend_kind(input int b);
        case (b)
            B_RX_AVAIL, B_TX_EMPTY:                          return PK_LEVEL;
            B_RX_OVR, B_TX_OVR, B_TX_UDR, B_PARITY,
            B_UNLOCK, B_LOCK:                                return PK_STICKY;
            default:                                         return PK_NONE;
        endcase
    endfunction

    function automatic logic [REG_W-1:0] status_mask();
        logic [REG_W-1:0] m;
        m = '0;
        for (int b = 0; b < REG_W; b++) begin
            m[b] = (pend_kind(b) != PK_NONE);
        end
        return m;
    endfunction

    function automatic logic [REG_W-1:0] enable_mask();
        logic [REG_W-1:0] m;
        m = status_mask();
        m[B_RX_DMA] = 1'b1;
        m[B_TX_DMA] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/aud_irq_edge.sv
module aud_irq_edge #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);

    logic [N-1:0] prev_q;

    // the level is taken as 0 while reset is held
    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;
    assign fall = ~lvl & prev_q;

endmodule

// File: rtl/aud_irq_pending.sv
module aud_irq_pending
    import aud_irq_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] hold_vec,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] pend
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        localparam pend_kind_e KIND = pend_kind(b);
        localparam logic       LIVE = (KIND != PK_NONE);
        logic q;

        // a set outranks a clear; a dropped hold condition empties the bit
        always_ff @(posedge clk) begin
            if (rst) q <= 1'b0;
            else     q <= LIVE & hold_vec[b] & (set_vec[b] | (q & ~clr_vec[b]));
        end
        assign pend[b] = q;

        if (KIND == PK_STICKY) begin : g_sticky
            AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
                q && !clr_vec[b] |=> q)
                else $error("sticky bit %0d dropped", b); // R4
            AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
                set_vec[b] |=> q)
                else $error("event on bit %0d lost", b); // R5
        end else if (KIND == PK_LEVEL) begin : g_level
            AST_LEVEL_DROP: assert property (@(posedge clk) disable iff (rst)
                !hold_vec[b] |=> !q)
                else $error("level bit %0d stayed without condition", b); // R6
        end
    end

endmodule

// File: rtl/aud_irq_out.sv
module aud_irq_out
    import aud_irq_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pend,
    input  logic [W-1:0] en,
    input  logic         rx_avail,
    input  logic         tx_room,
    output logic         irq,
    output logic         rx_dma_req,
    output logic         tx_dma_req
);

    logic irq_q;

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |(pend & en);
    end

    assign irq        = irq_q;
    assign rx_dma_req = en[B_RX_DMA] & rx_avail;
    assign tx_dma_req = en[B_TX_DMA] & tx_room;

endmodule

// File: rtl/aud_irq_ctrl.sv
module aud_irq_ctrl
    import aud_irq_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         reg_wr_en,
    input  logic         reg_sel,
    input  logic [W-1:0] reg_wdata,
    output logic [W-1:0] reg_rdata,
    input  logic         rx_avail,
    input  logic         tx_empty,
    input  logic         tx_room,
    input  logic         rx_ovr_ev,
    input  logic         tx_ovr_ev,
    input  logic         tx_udr_ev,
    input  logic         par_err_ev,
    input  logic         lock_flag,
    output logic         irq,
    output logic         rx_dma_req,
    output logic         tx_dma_req
);

    localparam logic [W-1:0] EN_MASK = W'(enable_mask());

    aud_evt_t         evt;
    logic [W-1:0]     en_q;
    logic [W-1:0]     status;
    logic [W-1:0]     set_vec;
    logic [W-1:0]     hold_vec;
    logic [W-1:0]     clr_vec;
    logic [N_EDGE-1:0] lvl, rise, fall;
    logic             wr_status, wr_enable;

    assign evt = '{rx_avail: rx_avail, tx_empty: tx_empty, tx_room: tx_room,
                   rx_ovr: rx_ovr_ev, tx_ovr: tx_ovr_ev, tx_udr: tx_udr_ev,
                   par_err: par_err_ev, lock: lock_flag};

    assign wr_status = reg_wr_en && (reg_sel_e'(reg_sel) == SEL_STATUS);
    assign wr_enable = reg_wr_en && (reg_sel_e'(reg_sel) == SEL_ENABLE);

    // enable word
    always_ff @(posedge clk) begin
        if (rst)            en_q <= '0;
        else if (wr_enable) en_q <= reg_wdata & EN_MASK;
    end

    // edge detection on level inputs
    always_comb begin
        lvl         = '0;
        lvl[E_RX]   = evt.rx_avail;
        lvl[E_TX]   = evt.tx_empty;
        lvl[E_LOCK] = evt.lock;
    end

    aud_irq_edge #(.N(N_EDGE)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  (lvl),
        .rise (rise),
        .fall (fall)
    );

    // source vectors for the pending word
    always_comb begin
        set_vec             = '0;
        set_vec[B_RX_AVAIL] = rise[E_RX];
        set_vec[B_TX_EMPTY] = rise[E_TX];
        set_vec[B_RX_OVR]   = evt.rx_ovr;
        set_vec[B_TX_OVR]   = evt.tx_ovr;
        set_vec[B_TX_UDR]   = evt.tx_udr;
        set_vec[B_PARITY]   = evt.par_err;
        set_vec[B_LOCK]     = rise[E_LOCK];
        set_vec[B_UNLOCK]   = fall[E_LOCK];

        hold_vec             = '1;
        hold_vec[B_RX_AVAIL] = evt.rx_avail;
        hold_vec[B_TX_EMPTY] = evt.tx_empty;

        clr_vec = wr_status ? reg_wdata : '0;
    end

    aud_irq_pending #(.W(W)) u_pend (
        .clk      (clk),
        .rst      (rst),
        .set_vec  (set_vec),
        .hold_vec (hold_vec),
        .clr_vec  (clr_vec),
        .pend     (status)
    );

    aud_irq_out #(.W(W)) u_out (
        .clk        (clk),
        .rst        (rst),
        .pend       (status),
        .en         (en_q),
        .rx_avail   (evt.rx_avail),
        .tx_room    (evt.tx_room),
        .irq        (irq),
        .rx_dma_req (rx_dma_req),
        .tx_dma_req (tx_dma_req)
    );

    assign reg_rdata = (reg_sel_e'(reg_sel) == SEL_STATUS) ? status : en_q;

    AST_LOCK_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_flag) |=> status[B_LOCK])
        else $error("lock edge missed"); // R7
    AST_UNLOCK_FALL: assert property (@(posedge clk) disable iff (rst)
        $fell(lock_flag) |=> status[B_UNLOCK])
        else $error("unlock edge missed"); // R7
    AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (rst)
        |(status & en_q) |=> irq)
        else $error("irq missing for enabled pending bit"); // R8
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        !(|(status & en_q)) |=> !irq)
        else $error("irq without enabled pending bit"); // R10
    AST_RX_DMA_SRC: assert property (@(posedge clk) disable iff (rst)
        rx_dma_req |-> rx_avail)
        else $error("rx dma request without data"); // R9

endmodule

// File: tb/tb_aud_irq_ctrl.sv
module tb_aud_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr_en, reg_sel;
    logic [31:0] reg_wdata, reg_rdata;
    logic        rx_avail, tx_empty, tx_room;
    logic        rx_ovr_ev, tx_ovr_ev, tx_udr_ev, par_err_ev, lock_flag;
    logic        irq, rx_dma_req, tx_dma_req;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    aud_irq_ctrl dut (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_avail(rx_avail),
        .tx_empty(tx_empty), .tx_room(tx_room), .rx_ovr_ev(rx_ovr_ev),
        .tx_ovr_ev(tx_ovr_ev), .tx_udr_ev(tx_udr_ev), .par_err_ev(par_err_ev),
        .lock_flag(lock_flag), .irq(irq), .rx_dma_req(rx_dma_req),
        .tx_dma_req(tx_dma_req)
    );

    typedef struct packed {
        logic        rx_av;
        logic        tx_em;
        logic        lck;
        logic        rovr;
        logic        tovr;
        logic        tudr;
        logic        par;
        logic        wr;
        logic [31:0] wd;
        logic [31:0] exp_st;
    } row_t;

    localparam int NROW = 17;
    localparam row_t TBL [0:NROW-1] = '{
        '{1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0, 1'b0, 32'h0,        32'h0000_0002},
        '{1'b0,1'b0,1'b0, 1'b0,1'b0,1'b1,1'b0, 1'b0, 32'h0,        32'h0000_0042},
        '{1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b1, 1'b0, 32'h0,        32'h0001_0042},
        '{1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b1, 32'h0000_0040, 32'h0001_0002},
        '{1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0, 1'b1, 32'h0000_0020, 32'h0001_0022},
        '{1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000},
        '{1'b0,1'b0,1'b1, 1'b0,1'b0,1'b0,1'b0, 1'b0, 32'h0,        32'h0004_0000},
        '{1'b0,1'b0,1'b1, 1'b0,1'b0,1'b0,1'b0, 1'b0, 32'h0,        32'h0004_0000},
        '{1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b0, 32'h0,        32'h0006_0000},
        '{1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b1, 32'h0006_0000, 32'h0000_0000},
        '{1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b0, 32'h0,        32'h0000_0001},
        '{1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b1, 32'h0000_0001, 32'h0000_0000},
        '{1'b0,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b0, 32'h0,        32'h0000_0010},
        '{1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b0, 32'h0,        32'h0000_0000},
        '{1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b0, 32'h0,        32'h0000_0001},
        '{1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b1, 32'h0000_0000, 32'h0000_0001},
        '{1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b0, 32'h0,        32'h0000_0000}
    };

    function automatic string row_req(input int i);
        case (i)
            0, 1, 2:     return "R4";
            4:           return "R5";
            3, 5, 9, 15: return "R3";
            6, 7, 8:     return "R7";
            default:     return "R6";
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic quiet_pulses();
        rx_ovr_ev = 0; tx_ovr_ev = 0; tx_udr_ev = 0; par_err_ev = 0;
        reg_wr_en = 0;
    endtask

    task automatic wr_reg(input logic sel, input logic [31:0] d);
        reg_wr_en = 1; reg_sel = sel; reg_wdata = d;
        step();
        reg_wr_en = 0;
    endtask

    task automatic read_reg(input logic sel, output logic [31:0] d);
        reg_sel = sel;
        #1 d = reg_rdata;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        rst = 1; reg_wr_en = 0; reg_sel = 0; reg_wdata = '0;
        rx_avail = 0; tx_empty = 0; tx_room = 1; lock_flag = 0;
        quiet_pulses();
        repeat (3) @(negedge clk);
        rst = 0;
        #1;

        // R1 reset state
        read_reg(1'b0, rd); chk("R1 enable", rd, 32'h0);
        read_reg(1'b1, rd); chk("R1 status", rd, 32'h0);
        chk("R1 irq", {31'h0, irq}, 32'h0);
        chk("R1 dma", {30'h0, rx_dma_req, tx_dma_req}, 32'h0);
        @(negedge clk);

        // table walk, enables all zero
        for (int i = 0; i < NROW; i++) begin
            rx_avail = TBL[i].rx_av; tx_empty = TBL[i].tx_em; lock_flag = TBL[i].lck;
            rx_ovr_ev = TBL[i].rovr; tx_ovr_ev = TBL[i].tovr;
            tx_udr_ev = TBL[i].tudr; par_err_ev = TBL[i].par;
            reg_wr_en = TBL[i].wr; reg_sel = 1'b1; reg_wdata = TBL[i].wd;
            step();
            quiet_pulses();
            read_reg(1'b1, rd);
            chk(row_req(i), rd, TBL[i].exp_st);
            chk("R10 irq masked", {31'h0, irq}, 32'h0);
        end

        // R2 enable masking
        @(negedge clk);
        wr_reg(1'b0, 32'hFFFF_FFFF);
        read_reg(1'b0, rd); chk("R2 enable mask", rd, 32'h0007_00F7);
        @(negedge clk);

        // R8 irq lag on set and on clear
        rx_ovr_ev = 1;
        step();
        rx_ovr_ev = 0;
        read_reg(1'b1, rd); chk("R8 status set", rd, 32'h0000_0002);
        chk("R8 irq lag", {31'h0, irq}, 32'h0);
        step();
        chk("R8 irq up", {31'h0, irq}, 32'h1);
        wr_reg(1'b1, 32'h0000_0002);
        read_reg(1'b1, rd); chk("R3 cleared", rd, 32'h0);
        chk("R8 irq holds one cycle", {31'h0, irq}, 32'h1);
        step();
        chk("R8 irq down", {31'h0, irq}, 32'h0);

        // R10 pending but not enabled
        wr_reg(1'b0, 32'h0004_0000);
        par_err_ev = 1;
        step();
        par_err_ev = 0;
        step(); step();
        read_reg(1'b1, rd); chk("R10 status set", rd, 32'h0001_0000);
        chk("R10 irq low", {31'h0, irq}, 32'h0);
        wr_reg(1'b1, 32'hFFFF_FFFF);

        // R9 DMA requests
        wr_reg(1'b0, 32'h0000_0004);
        rx_avail = 1; tx_room = 1;
        #1;
        chk("R9 rx dma", {31'h0, rx_dma_req}, 32'h1);
        chk("R9 tx dma off", {31'h0, tx_dma_req}, 32'h0);
        @(negedge clk);
        wr_reg(1'b0, 32'h0000_0084);
        #1 chk("R9 tx dma on", {31'h0, tx_dma_req}, 32'h1);
        rx_avail = 0;
        #1 chk("R9 rx dma off", {31'h0, rx_dma_req}, 32'h0);
        tx_room = 0;
        #1 chk("R9 tx dma room", {31'h0, tx_dma_req}, 32'h0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule